// File: doc/BRIEF.md
# Event Sampling Selector

This block decides, once per assembled event, whether that event is copied into the sampling buffers. Each output link has its own sampling buffer. The decision is a single strobe that every link obeys, so the links always sample the same events. An event is eligible when two conditions hold. Its type must share at least one set bit with a programmable type mask. A prescaler that counts type-matched events must also be due.

Two modes are available. In random mode, an eligible event is taken only when every link's buffer reports free space. If any buffer is busy, the event is passed over and is not retried. In full mode, every eligible event is taken whatever the buffer state. A software link-full request is raised while no buffer has room, so the data path upstream stalls instead of losing events. Under a high trigger rate this stall can eventually cause busy to be asserted toward the trigger system.

Top module: `evsamp_selector`

## Requirements
- R1: An event is type-matched only when the bitwise AND of `type_mask` and `evt_type` is nonzero. A mask of zero never produces a sample.
- R2: `sample_go` is a one-cycle pulse in the clock cycle after an event strobe (`evt_valid`) that is accepted. Without an accepted strobe it stays low. The same single strobe serves all links.
- R3: The prescaler counts type-matched strobes and picks every Nth one, counting from reset, where N is `prescale`. A `prescale` of 0 or 1 picks every matched event. The count advances on every matched strobe, whatever the mode or buffer state.
- R4: Random mode is `mode_full` = 0. In this mode a picked event gives a pulse only if every bit of `buf_free` is 1. Otherwise the event is skipped without a pulse.
- R5: Full mode is `mode_full` = 1. In this mode every picked event gives a pulse, whatever the value of `buf_free`.
- R6: `soft_lff` is high in the cycle after a cycle in which `mode_full` is 1 and `buf_free` is all zero. It is low after any cycle in random mode.
- R7: In full mode, `soft_lff` drops in the cycle after any one bit of `buf_free` becomes 1.
- R8: While `rst_n` is low, both outputs are 0 and the prescale count is cleared.
- R9: If `prescale` is lowered to a value at or below the number of matched events already counted, the next matched event is picked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe for an assembled event |
| evt_type | input | TYPE_W (8) | Type bits of the strobed event |
| buf_free | input | N_LINKS (4) | Per-link flag, 1 when that link's sampling buffer can accept an event |
| mode_full | input | 1 | 0 selects random mode, 1 selects full mode |
| type_mask | input | TYPE_W (8) | Event-type mask |
| prescale | input | PSC_W (16) | Prescale factor N |
| sample_go | output | 1 | Common sample strobe for all links |
| soft_lff | output | 1 | Software link-full request (full mode) |

## Verification
The hardest situation to reach from the ports is one where the prescaler becomes due exactly when a single buffer is busy in random mode. There the event has to be dropped while the count still restarts, and the effect only shows N matched events later. The stimulus steers into this case directly with a short prescale and one `buf_free` bit held low. A long stretch of random strobes, types, masks, buffer flags and mode changes then follows. Throughout, a behavioural model with its own integer count predicts both outputs on every clock.

// File: rtl/evsamp_pkg.sv
package evsamp_pkg;

  typedef enum logic {
    SMP_RANDOM = 1'b0,
    SMP_FULL   = 1'b1
  } smp_mode_e;

  localparam int DEF_TYPE_W  = 8;
  localparam int DEF_PSC_W   = 16;
  localparam int DEF_N_LINKS = 4;

endpackage

// File: rtl/evsamp_type_filter.sv
module evsamp_type_filter #(
  parameter int TYPE_W = evsamp_pkg::DEF_TYPE_W
) (
  input  logic [TYPE_W-1:0] evt_type,
  input  logic [TYPE_W-1:0] type_mask,
  output logic              match
);

  function automatic logic has_overlap(input logic [TYPE_W-1:0] a,
                                       input logic [TYPE_W-1:0] b);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < TYPE_W; i++) begin
      hit = hit | (a[i] & b[i]);
    end
    return hit;
  endfunction

  assign match = has_overlap(evt_type, type_mask);

endmodule

// File: rtl/evsamp_prescaler.sv
module evsamp_prescaler #(
  parameter int PSC_W = evsamp_pkg::DEF_PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [PSC_W-1:0] prescale,
  output logic             pick
);

  localparam logic [PSC_W:0] ONE_X = {{PSC_W{1'b0}}, 1'b1};

  logic [PSC_W-1:0] cnt_q;
  logic             due;

  // Due when the event being counted now reaches the period; 0 and 1 mean always.
  function automatic logic is_due(input logic [PSC_W-1:0] cnt,
                                  input logic [PSC_W-1:0] psc);
    logic [PSC_W:0] seen;
    seen = {1'b0, cnt} + ONE_X;
    if ({1'b0, psc} <= ONE_X) return 1'b1;
    return seen >= {1'b0, psc};
  endfunction

  assign due  = is_due(cnt_q, prescale);
  assign pick = step & due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      if (due) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PICK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pick |-> step); // R3

  AST_PICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pick |=> (cnt_q == '0)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/evsamp_gate.sv
module evsamp_gate #(
  parameter int N_LINKS = evsamp_pkg::DEF_N_LINKS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pick,
  input  evsamp_pkg::smp_mode_e   mode,
  input  logic [N_LINKS-1:0]      buf_free,
  output logic                    all_free,
  output logic                    any_free,
  output logic                    sample_go,
  output logic                    soft_lff
);

  import evsamp_pkg::*;

  logic take;

  // Reduce the per-link flags one link at a time.
  logic [N_LINKS:0] and_chain;
  logic [N_LINKS:0] or_chain;
  assign and_chain[0] = 1'b1;
  assign or_chain[0]  = 1'b0;
  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    assign and_chain[g+1] = and_chain[g] & buf_free[g];
    assign or_chain[g+1]  = or_chain[g]  | buf_free[g];
  end
  assign all_free = and_chain[N_LINKS];
  assign any_free = or_chain[N_LINKS];

  function automatic logic accept(input logic p, input smp_mode_e m,
                                  input logic room);
    return p & ((m == SMP_FULL) | room);
  endfunction

  assign take = accept(pick, mode, all_free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_go <= 1'b0;
      soft_lff  <= 1'b0;
    end else begin
      sample_go <= take;
      soft_lff  <= (mode == SMP_FULL) & ~any_free;
    end
  end

  AST_GO_FROM_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_go |-> $past(pick)); // R2

  AST_RANDOM_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && mode == SMP_RANDOM && !all_free) |=> !sample_go); // R4

  AST_FULL_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && mode == SMP_FULL) |=> sample_go); // R5

  AST_LFF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SMP_RANDOM) |=> !soft_lff); // R6

  AST_LFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_lff && any_free) |=> !soft_lff); // R7

endmodule

// File: rtl/evsamp_selector.sv
module evsamp_selector #(
  parameter int TYPE_W  = evsamp_pkg::DEF_TYPE_W,
  parameter int PSC_W   = evsamp_pkg::DEF_PSC_W,
  parameter int N_LINKS = evsamp_pkg::DEF_N_LINKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [TYPE_W-1:0]  evt_type,
  input  logic [N_LINKS-1:0] buf_free,
  input  logic               mode_full,
  input  logic [TYPE_W-1:0]  type_mask,
  input  logic [PSC_W-1:0]   prescale,
  output logic               sample_go,
  output logic               soft_lff
);

  import evsamp_pkg::*;

  logic      ev_match;
  logic      ev_step;
  logic      ev_pick;
  logic      links_all_free;
  logic      links_any_free;
  smp_mode_e mode;

  assign mode    = smp_mode_e'(mode_full);
  assign ev_step = evt_valid & ev_match;

  evsamp_type_filter #(.TYPE_W(TYPE_W)) u_filter (
    .evt_type  (evt_type),
    .type_mask (type_mask),
    .match     (ev_match)
  );

  evsamp_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (ev_step),
    .prescale (prescale),
    .pick     (ev_pick)
  );

  evsamp_gate #(.N_LINKS(N_LINKS)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (ev_pick),
    .mode      (mode),
    .buf_free  (buf_free),
    .all_free  (links_all_free),
    .any_free  (links_any_free),
    .sample_go (sample_go),
    .soft_lff  (soft_lff)
  );

  AST_GO_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_go |-> $past(ev_match)); // R1

  AST_GO_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_go |-> $past(evt_valid)); // R2

  AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (type_mask == '0) |=> !sample_go); // R1

endmodule

// File: tb/sim_evsamp_selector.sv
module sim_evsamp_selector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_type = '0;
  logic [3:0]  buf_free = 4'hF;
  logic        mode_full = 1'b0;
  logic [7:0]  type_mask = 8'hFF;
  logic [15:0] prescale = 16'd1;
  logic        sample_go;
  logic        soft_lff;

  int n_run  = 0;
  int n_fail = 0;
  int m_cnt  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  evsamp_selector u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
    .buf_free(buf_free), .mode_full(mode_full), .type_mask(type_mask),
    .prescale(prescale), .sample_go(sample_go), .soft_lff(soft_lff)
  );

  task automatic chk(input string tag, input string what,
                     input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock with the current inputs; the model predicts both outputs.
  task automatic cyc(input string tag);
    bit matched, picked, exp_go, exp_lff;
    int period;
    matched = (type_mask & evt_type) != 0;
    picked  = 1'b0;
    if (evt_valid && matched) begin
      period = (prescale <= 1) ? 1 : int'(prescale);
      if (m_cnt + 1 >= period) begin
        picked = 1'b1;
        m_cnt  = 0;
      end else begin
        m_cnt++;
      end
    end
    exp_go  = picked && (mode_full || buf_free == 4'hF);
    exp_lff = mode_full && buf_free == 4'h0;
    @(posedge clk);
    #5;
    chk(tag, "sample_go", sample_go, exp_go);
    chk(tag, "soft_lff", soft_lff, exp_lff);
    evt_valid = 1'b0;
  endtask

  task automatic ev(input logic [7:0] ty, input string tag);
    evt_valid = 1'b1;
    evt_type  = ty;
    cyc(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset holds outputs low even with full mode and no buffer free
    mode_full = 1'b1;
    buf_free  = 4'h0;
    evt_valid = 1'b1;
    evt_type  = 8'h01;
    repeat (3) begin
      @(posedge clk);
      #5;
      chk("R8", "sample_go", sample_go, 1'b0);
      chk("R8", "soft_lff", soft_lff, 1'b0);
    end
    evt_valid = 1'b0;
    mode_full = 1'b0;
    buf_free  = 4'hF;
    rst_n     = 1'b1;
    m_cnt     = 0;
    cyc("R8");

    // R1: zero mask, then disjoint and overlapping types
    type_mask = 8'h00;
    ev(8'hFF, "R1");
    ev(8'h01, "R1");
    type_mask = 8'h04;
    ev(8'h03, "R1");
    ev(8'h04, "R1");
    ev(8'h8C, "R1");

    // R2: strobes and idle cycles
    type_mask = 8'hFF;
    ev(8'h10, "R2");
    cyc("R2");
    cyc("R2");
    ev(8'h20, "R2");
    ev(8'h40, "R2");

    // R3: one in three; unmatched events do not count
    prescale  = 16'd3;
    type_mask = 8'h01;
    for (int i = 0; i < 7; i++) begin
      ev(8'h01, "R3");
      ev(8'h02, "R3");
    end
    prescale = 16'd0;
    ev(8'h01, "R3");
    ev(8'h01, "R3");

    // R4: due event lands while one buffer is busy, then count restarts
    prescale = 16'd2;
    ev(8'h01, "R4");
    buf_free = 4'b1011;
    ev(8'h01, "R4");
    buf_free = 4'hF;
    ev(8'h01, "R4");
    ev(8'h01, "R4");
    buf_free = 4'b0111;
    ev(8'h01, "R4");
    ev(8'h01, "R4");

    // R5/R6/R7: full mode with no room, release by one buffer
    mode_full = 1'b1;
    buf_free  = 4'h0;
    prescale  = 16'd1;
    ev(8'h01, "R5");
    ev(8'h01, "R5");
    cyc("R6");
    buf_free = 4'b0100;
    cyc("R7");
    cyc("R7");
    buf_free = 4'h0;
    cyc("R6");
    mode_full = 1'b0;
    cyc("R6");
    ev(8'h01, "R6");

    // R9: lower prescale below the count already reached
    buf_free = 4'hF;
    prescale = 16'd5;
    ev(8'h01, "R9");
    ev(8'h01, "R9");
    ev(8'h01, "R9");
    prescale = 16'd2;
    ev(8'h01, "R9");
    ev(8'h01, "R9");

    // Mixed stimulus across all rules
    for (int i = 0; i < 3000; i++) begin
      evt_valid = ($urandom_range(0, 2) != 0);
      evt_type  = 8'($urandom_range(0, 255));
      type_mask = ($urandom_range(0, 15) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      buf_free  = ($urandom_range(0, 3) == 0) ? 4'h0 : 4'($urandom_range(0, 15));
      if ($urandom_range(0, 40) == 0) mode_full = ~mode_full;
      if ($urandom_range(0, 60) == 0) prescale = 16'($urandom_range(0, 6));
      cyc("R4");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule